// File: doc/BRIEF.md
# ADC Dual-Channel Window Watchdog

This block sits beside an analog-to-digital converter and inspects each finished conversion. Only results tagged with channel 6 or channel 7 are examined. Each of these two channels has its own programmable window, made of an upper limit and a lower limit. A result that falls outside the window raises a shared watchdog request and sets a sticky flag. The flag records which channel and which limit caused the event.

Software programs the four limits, reads the flags and controls the interrupt through a small register bus. The request drives a maskable interrupt line. When software clears the request, the hardware also empties every flag, so the next event starts from a clean record.

Top module: `adc_window_guard`

## Requirements
- R1: A guarded result greater than or equal to its channel's upper limit sets the request and sets the flag for that limit. Channel 6 upper uses flag bit 7 and channel 7 upper uses flag bit 5.
- R2: A guarded result strictly below its channel's lower limit sets the request and sets the flag for that limit. Channel 6 lower uses flag bit 6 and channel 7 lower uses flag bit 4.
- R3: A result that is at least the lower limit and below the upper limit is normal and changes neither the flags nor the request. A result equal to the lower limit is normal.
- R4: Conversions on any channel other than 6 or 7 leave the flags and the request unchanged.
- R5: The limits are writable and readable at offset 0x8 (ch6 upper), 0x9 (ch6 lower), 0xA (ch7 upper) and 0xB (ch7 lower). A limit write is used by the first conversion after that write.
- R6: A read at offset 0xC returns the four flags in bits 7..4, and bits 3..0 always read as 1.
- R7: After reset all flags, the request and the enable are 0, the upper limits read 0xFF and the lower limits read 0x00.
- R8: Writing 0 to bit 0 (request) at offset 0xD clears the request and every flag. Writing 1 to bit 0 leaves the request unchanged.
- R9: Bit 1 at offset 0xD is the interrupt enable. The irq output is high exactly when both the request and the enable are set. A read of 0xD returns the enable in bit 1 and the request in bit 0.
- R10: Flags are sticky. A later normal result does not clear them, and several flags can be set at once.
- R11: If an out-of-range result arrives in the same cycle as a software clear, the new event's flag and the request end up set, and all other flags end up cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cv_done | input | 1 | One-cycle strobe marking a finished conversion |
| cv_chan | input | 3 | Channel number of the finished conversion |
| cv_data | input | 8 | Unsigned conversion result |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for bus_addr (combinational) |
| irq | output | 1 | Maskable watchdog interrupt request |

## Verification
A conversion strobe and a software clear of the request can land on the same clock edge. The bench provokes this with a flag already set from an earlier event: in a single cycle it writes 0 to the request bit and presents a channel 6 result below its lower limit. The result is judged by reading the flag and control registers and sampling irq afterwards. The old flag must be gone, and the new lower-limit flag and the request must be present.

// File: rtl/adc_wg_pkg.sv
// Package: register offsets and bit positions shared by the watchdog modules.
// Assumes a register page addressed by a small offset; only the offsets
// listed here are decoded.
package adc_wg_pkg;
    localparam int unsigned NUM_LIM    = 4;    // two channels x two limits
    localparam int unsigned OFF_THR0   = 8;    // first limit register
    localparam int unsigned OFF_FLAGS  = 12;   // compare-result flags
    localparam int unsigned OFF_CTRL   = 13;   // request / enable
    localparam int unsigned CTRL_REQ   = 0;    // request bit position
    localparam int unsigned CTRL_EN    = 1;    // enable bit position
endpackage

// File: rtl/adc_wg_regs.sv
// Module: limit registers and interrupt enable.
// Decodes bus writes to the four limit registers and the control register,
// and produces a one-cycle clear pulse when software writes 0 to the
// request bit. Assumes DW >= 2.
module adc_wg_regs
    import adc_wg_pkg::*;
#(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic [AW-1:0]              bus_addr,
    input  logic [DW-1:0]              bus_wdata,
    output logic [NUM_LIM-1:0][DW-1:0] thr,
    output logic                       en,
    output logic                       clr
);
    logic ctrl_wr;

    // Decode a write to the control register.
    always_comb ctrl_wr = bus_wr && (int'(bus_addr) == OFF_CTRL);

    // Clear pulse: software writes 0 to the request bit.
    always_comb clr = ctrl_wr && !bus_wdata[CTRL_REQ];

    // Enable bit storage.
    always_ff @(posedge clk) begin
        if (!rst_n)       en <= 1'b0;
        else if (ctrl_wr) en <= bus_wdata[CTRL_EN];
    end

    // One storage element per limit; even index = upper, odd index = lower.
    for (genvar k = 0; k < NUM_LIM; k++) begin : g_thr
        localparam logic [DW-1:0] RST_VAL = (k % 2 == 0) ? {DW{1'b1}} : '0;
        always_ff @(posedge clk) begin
            if (!rst_n)
                thr[k] <= RST_VAL;
            else if (bus_wr && (int'(bus_addr) == OFF_THR0 + k))
                thr[k] <= bus_wdata;
        end

        // R5: a write to a limit register is held on the next cycle
        p_thr_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && (int'(bus_addr) == OFF_THR0 + k)) |=> (thr[k] == $past(bus_wdata)));
    end

    // R9: the enable follows the written control value
    p_en_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (en == $past(bus_wdata[CTRL_EN])));
endmodule

// File: rtl/adc_wg_cmp.sv
// Module: window comparator for one guarded channel.
// Fires only in the strobe cycle of a conversion on channel CH. Upper is
// inclusive (>= is out of range); lower is exclusive (< is out of range).
module adc_wg_cmp #(
    parameter int unsigned DW = 8,
    parameter int unsigned CW = 3,
    parameter int unsigned CH = 6
) (
    input  logic          cv_done,
    input  logic [CW-1:0] cv_chan,
    input  logic [DW-1:0] cv_data,
    input  logic [DW-1:0] upper,
    input  logic [DW-1:0] lower,
    output logic          hit_hi,
    output logic          hit_lo
);
    logic sel;

    // Conversion belongs to this channel.
    always_comb sel = cv_done && (int'(cv_chan) == CH);

    // Out-of-range tests against both limits.
    always_comb begin
        hit_hi = sel && (cv_data >= upper);
        hit_lo = sel && (cv_data <  lower);
    end
endmodule

// File: rtl/adc_wg_flags.sv
// Module: sticky compare-result flags and the shared watchdog request.
// New hits are ORed in after the clear is applied, so an event arriving
// with a software clear survives it.
module adc_wg_flags
    import adc_wg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LIM-1:0] hit,
    input  logic               clr,
    output logic [NUM_LIM-1:0] flags,
    output logic               req
);
    logic hit_any;

    // Any limit crossed this cycle.
    always_comb hit_any = |hit;

    // Flag and request update: clear first, then accumulate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
            req   <= 1'b0;
        end else begin
            flags <= (clr ? '0 : flags) | hit;
            req   <= (clr ? 1'b0 : req) | hit_any;
        end
    end

    // R1: any out-of-range hit raises the request
    p_hit_sets_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hit_any |=> req);

    // R8: a clear with no new event empties everything
    p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !hit_any) |=> (flags == '0 && !req));

    // R10: without a clear no flag is lost
    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((flags & $past(flags)) == $past(flags)));

    // R11: an event coinciding with a clear keeps the request
    p_race_keeps_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && hit_any) |=> (req && flags != '0));
endmodule

// File: rtl/adc_window_guard.sv
// Module: top of the dual-channel window watchdog.
// Instantiates the register block, one comparator per guarded channel and
// the flag store, and builds the read-back mux. Flag bit order (MSB first):
// ch6 upper, ch6 lower, ch7 upper, ch7 lower. Assumes DW >= 8.
module adc_window_guard
    import adc_wg_pkg::*;
#(
    parameter int unsigned DW   = 8,
    parameter int unsigned AW   = 4,
    parameter int unsigned CW   = 3,
    parameter int unsigned CH_A = 6,
    parameter int unsigned CH_B = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cv_done,
    input  logic [CW-1:0] cv_chan,
    input  logic [DW-1:0] cv_data,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq
);
    localparam int unsigned NCH = 2;
    localparam int unsigned PAD = DW - NUM_LIM;

    logic [NUM_LIM-1:0][DW-1:0] thr;
    logic [NUM_LIM-1:0]         hit;
    logic [NUM_LIM-1:0]         flags;
    logic                       en;
    logic                       clr;
    logic                       req;

    adc_wg_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .thr       (thr),
        .en        (en),
        .clr       (clr)
    );

    // One comparator per guarded channel; channel g uses limits 2g and 2g+1.
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam int unsigned CH_NUM = (g == 0) ? CH_A : CH_B;
        adc_wg_cmp #(.DW(DW), .CW(CW), .CH(CH_NUM)) u_cmp (
            .cv_done (cv_done),
            .cv_chan (cv_chan),
            .cv_data (cv_data),
            .upper   (thr[2*g]),
            .lower   (thr[2*g+1]),
            .hit_hi  (hit[NUM_LIM-1-2*g]),
            .hit_lo  (hit[NUM_LIM-2-2*g])
        );
    end

    adc_wg_flags u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .clr   (clr),
        .flags (flags),
        .req   (req)
    );

    // Maskable interrupt output.
    always_comb irq = req && en;

    // Register read-back mux.
    always_comb begin
        bus_rdata = '0;
        if (int'(bus_addr) >= OFF_THR0 && int'(bus_addr) < OFF_THR0 + NUM_LIM)
            bus_rdata = thr[int'(bus_addr) - OFF_THR0];
        else if (int'(bus_addr) == OFF_FLAGS)
            bus_rdata = {flags, {PAD{1'b1}}};
        else if (int'(bus_addr) == OFF_CTRL) begin
            bus_rdata[CTRL_REQ] = req;
            bus_rdata[CTRL_EN]  = en;
        end
    end

    // R4: conversions on unguarded channels touch no flag
    p_ignore_other_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cv_done && int'(cv_chan) != CH_A && int'(cv_chan) != CH_B && !clr)
        |=> ($stable(flags) && $stable(req)));
endmodule

// File: tb/sim_adc_window_guard.sv
`timescale 1ns/100ps
module sim_adc_window_guard;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cv_done = 1'b0;
    logic [2:0] cv_chan = '0;
    logic [7:0] cv_data = '0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;

    always #2.5 clk = ~clk;

    adc_window_guard u0 (
        .clk(clk), .rst_n(rst_n), .cv_done(cv_done), .cv_chan(cv_chan),
        .cv_data(cv_data), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    typedef struct {
        int         addr;   // -1 selects the irq pin
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    event  chk_ev;
    int    vectors = 0;
    int    miscompares = 0;
    bit    done = 0;

    // Requirement-level model.
    logic [7:0] m_thr [4] = '{8'hFF, 8'h00, 8'hFF, 8'h00};
    logic [3:0] m_flags = '0;
    logic       m_req = 1'b0;
    logic       m_en = 1'b0;

    function automatic logic [7:0] model_read(int a);
        if (a < 0)              return {7'b0, m_req & m_en};
        if (a >= 8 && a <= 11)  return m_thr[a-8];
        if (a == 12)            return {m_flags, 4'hF};
        if (a == 13)            return {6'b0, m_en, m_req};
        return 8'h00;
    endfunction

    function automatic logic [3:0] model_hits(int ch, logic [7:0] d);
        logic [3:0] h = '0;
        if (ch == 6) begin
            h[3] = (d >= m_thr[0]);
            h[2] = (d <  m_thr[1]);
        end else if (ch == 7) begin
            h[1] = (d >= m_thr[2]);
            h[0] = (d <  m_thr[3]);
        end
        return h;
    endfunction

    // Monitor: pops expected items and compares them with the outputs.
    initial begin
        item_t it;
        logic [7:0] act;
        forever begin
            @(chk_ev);
            #1;
            while (q.size() > 0) begin
                it  = q.pop_front();
                act = (it.addr < 0) ? {7'b0, irq} : bus_rdata;
                vectors++;
                if (act !== it.exp) begin
                    miscompares++;
                    $display("FAIL %s: addr %0d got %02h expected %02h",
                             it.tag, it.addr, act, it.exp);
                end
            end
        end
    end

    // Driver: presents an offset (or irq) and queues the expected value.
    task automatic check(int a, string tag);
        item_t it;
        @(negedge clk);
        if (a >= 0) bus_addr = 4'(a);
        it.addr = a;
        it.exp  = model_read(a);
        it.tag  = tag;
        q.push_back(it);
        -> chk_ev;
        #2;
    endtask

    task automatic bus_write(int a, logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
        if (a >= 8 && a <= 11) m_thr[a-8] = d;
        if (a == 13) begin
            m_en = d[1];
            if (!d[0]) begin m_flags = '0; m_req = 1'b0; end
        end
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Conversion, optionally in the same cycle as a request clear.
    task automatic convert(int ch, logic [7:0] d, bit with_clr);
        logic [3:0] h;
        @(negedge clk);
        h = model_hits(ch, d);
        cv_done = 1'b1; cv_chan = 3'(ch); cv_data = d;
        if (with_clr) begin
            bus_wr = 1'b1; bus_addr = 4'd13; bus_wdata = {6'b0, m_en, 1'b0};
            m_flags = '0; m_req = 1'b0;
        end
        m_flags = m_flags | h;
        m_req   = m_req | (|h);
        @(negedge clk);
        cv_done = 1'b0; bus_wr = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R7: reset state of limits, flags, control and irq
        check(8,  "R7 ch6 upper reset");
        check(9,  "R7 ch6 lower reset");
        check(10, "R7 ch7 upper reset");
        check(11, "R7 ch7 lower reset");
        check(12, "R7/R6 flags reset, low nibble ones");
        check(13, "R7 control reset");
        check(-1, "R7 irq reset");

        // R5: program and read back the limits
        bus_write(8, 8'hC0); bus_write(9, 8'h40);
        bus_write(10, 8'hA0); bus_write(11, 8'h20);
        check(8,  "R5 ch6 upper");
        check(9,  "R5 ch6 lower");
        check(10, "R5 ch7 upper");
        check(11, "R5 ch7 lower");

        // R3: in-window results, including equal to the lower limit
        convert(6, 8'h40, 0); convert(6, 8'hBF, 0);
        convert(7, 8'h20, 0); convert(7, 8'h9F, 0);
        check(12, "R3 in-window leaves flags clear");
        check(13, "R3 in-window leaves request clear");

        // R4: other channels with extreme values are ignored
        convert(0, 8'hFF, 0); convert(2, 8'h00, 0);
        convert(5, 8'hFF, 0); convert(3, 8'h00, 0);
        check(12, "R4 unguarded channels leave flags");
        check(13, "R4 unguarded channels leave request");

        // R1: equal to upper limit is out of range; masked, so no irq
        convert(6, 8'hC0, 0);
        check(12, "R1 ch6 upper flag bit7");
        check(-1, "R9 irq masked while enable is 0");

        // R9: enable, writing 1 to request keeps it
        bus_write(13, 8'h03);
        check(13, "R8/R9 write 1 to request keeps it, enable set");
        check(-1, "R9 irq with request and enable");

        // R10 / R2: sticky and multiple flags
        convert(6, 8'h80, 0);
        check(12, "R10 normal result keeps flag");
        convert(7, 8'h1F, 0);
        check(12, "R2 ch7 lower flag bit4");
        convert(7, 8'hFF, 0);
        check(12, "R1 ch7 upper flag bit5");
        convert(6, 8'h00, 0);
        check(12, "R2/R10 ch6 lower flag bit6, all four set");

        // R8: software clear empties flags and request
        bus_write(13, 8'h02);
        check(12, "R8 flags cleared with request");
        check(13, "R8 request cleared");
        check(-1, "R8 irq dropped after clear");

        // R5: new lower limit used by the next conversion
        bus_write(9, 8'h10);
        convert(6, 8'h30, 0);
        check(12, "R5 lowered limit makes 0x30 normal");
        convert(6, 8'h0F, 0);
        check(12, "R5/R2 below new ch6 lower limit");
        bus_write(13, 8'h02);
        check(12, "R8 second clear");

        // R11: clear and event in the same cycle
        convert(7, 8'hA0, 0);
        check(12, "R11 setup ch7 upper flag");
        convert(6, 8'h05, 1);
        check(12, "R11 new flag kept, old flag cleared");
        check(13, "R11 request kept");
        check(-1, "R11 irq kept");

        // R9: masking again
        bus_write(13, 8'h01);
        check(-1, "R9 irq masked, request pending");
        check(13, "R9 control readback");

        done = 1;
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule